// File: doc/BRIEF.md
# Column Checksum Group Error Localizer

This block identifies which device of a nine-device rank is faulty once a per-codeword check has flagged an error. A rank stores each codeword as nine 16-bit symbols, one symbol per device. A group of codewords shares one set of per-device checksums. Each checksum is a one's-complement sum of the symbols that one device contributes across the group, and it is stored in that same device.

A sequencer outside the block pulses `start` and then streams the group's codewords, one per cycle, marked by `sym_valid`. The block keeps one running one's-complement sum per device. After the last codeword, the sequencer presents the nine stored checksums with `stored_valid`. The block compares each stored checksum with its recomputed sum.

When exactly one device disagrees, the block reports that device as the erasure position for the correction stage. When no device disagrees, or more than one does, it raises an uncorrectable-error flag. Memory sequencing, address generation and the erasure correction itself are done elsewhere.

Top module: `clg_localizer`

## Requirements
- R1: After reset, `done`, `located` and `due` are 0 and `dev_idx` is 0.
- R2: A `start` pulse clears every device sum and the codeword count to zero, and it clears `located`, `due` and `dev_idx`. A group that is partly streamed when `start` arrives is discarded.
- R3: Device d owns bits [16d+15:16d] of `sym_word` and of `stored_sums`. Its sum is built by 16-bit one's-complement addition: the carry out of bit 15 is added back into bit 0.
- R4: Exactly GROUP_LEN codewords (256 by default) are accumulated after `start`. A `sym_valid` beat after the group is full has no effect on the result.
- R5: The values 0x0000 and 0xFFFF are both treated as zero. A stored checksum and a recomputed sum that are each one of these two values count as a match.
- R6: When exactly one device d mismatches, the result is `located`=1, `dev_idx`=d and `due`=0.
- R7: When no device mismatches, or two or more devices mismatch, the result is `due`=1, `located`=0 and `dev_idx`=0.
- R8: `done` is high for exactly one cycle, in the cycle after the edge that accepts `stored_valid`. `located`, `due` and `dev_idx` keep their values until the next `start`.
- R9: `stored_valid` is accepted only once the group is full. Outside that phase it has no effect. Presenting it while codewords are still being collected is a protocol violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a new group; clears sums and results |
| sym_valid | input | 1 | `sym_word` holds a codeword |
| sym_word | input | 144 | Nine 16-bit symbols; device d at [16d+15:16d] |
| stored_valid | input | 1 | `stored_sums` holds the group's checksums |
| stored_sums | input | 144 | Nine stored 16-bit checksums, same lane order |
| done | output | 1 | One-cycle pulse when a verdict is ready |
| located | output | 1 | Exactly one device mismatched |
| dev_idx | output | 4 | Index of the mismatching device |
| due | output | 1 | Uncorrectable: zero or several mismatches |

## Verification
The verdict is due one cycle after the edge that accepts `stored_valid`, since the comparison result passes through a single output register. `done` falls again on the following edge. The bench drives every input on the falling edge and reads `done`, `located`, `dev_idx` and `due` at the next falling edge, so every result is sampled half a period after the register that produces it. The next sample, one cycle later, confirms that `done` has dropped while the verdict fields are held. Checks that some stimulus is ignored read the held verdict in the cycles after that stimulus, before any new `start`.

// File: rtl/clg_pkg.sv
package clg_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_COLLECT = 2'd1,
    PH_CHECK   = 2'd2
  } phase_t;
endpackage

// File: rtl/clg_ocsum_acc.sv
module clg_ocsum_acc #(
  parameter int SYM_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             add_en,
  input  logic [SYM_W-1:0] sym,
  output logic [SYM_W-1:0] acc
);
  logic [SYM_W:0]   wide_sum;
  logic [SYM_W-1:0] folded;

  // End-around carry: the carry out is added back into bit 0; this cannot overflow again.
  always_comb begin
    wide_sum = {1'b0, acc} + {1'b0, sym};
    folded   = wide_sum[SYM_W-1:0] + {{(SYM_W-1){1'b0}}, wide_sum[SYM_W]};
  end

  always_ff @(posedge clk) begin
    if (rst || clr) acc <= '0;
    else if (add_en) acc <= folded;
  end

  // R2: a clear leaves the sum at zero
  p_clear_zero_r2: assert property (@(posedge clk) disable iff (rst) clr |=> acc == '0);
  // R3: without an enable the sum holds
  p_hold_idle_r3: assert property (@(posedge clk) disable iff (rst) (!clr && !add_en) |=> $stable(acc));
endmodule

// File: rtl/clg_ctrl.sv
module clg_ctrl
  import clg_pkg::*;
#(
  parameter int GROUP_LEN = 256,
  localparam int CNT_W = $clog2(GROUP_LEN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic sym_valid,
  input  logic stored_valid,
  output logic acc_clr,
  output logic acc_en,
  output logic fire
);
  phase_t           phase;
  logic [CNT_W-1:0] cnt;

  assign acc_clr = start;
  assign acc_en  = !start && sym_valid && (phase == PH_COLLECT);
  assign fire    = !start && stored_valid && (phase == PH_CHECK);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else if (start) begin
      phase <= PH_COLLECT;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_COLLECT: if (sym_valid) begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(GROUP_LEN - 1)) phase <= PH_CHECK;
        end
        PH_CHECK: if (stored_valid) phase <= PH_IDLE;
        default: ;
      endcase
    end
  end

  // R4: the codeword count never passes the group length
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst) cnt <= CNT_W'(GROUP_LEN));
  // R4: the compare phase is reached only with a full group
  p_full_group_r4: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_CHECK) |-> (cnt == CNT_W'(GROUP_LEN)));
  // R9: stored checksums must not arrive while codewords are still being collected
  p_early_stored_r9: assert property (@(posedge clk) disable iff (rst)
    (stored_valid && !start) |-> (phase != PH_COLLECT));
endmodule

// File: rtl/clg_verdict.sv
module clg_verdict #(
  parameter int SYM_W   = 16,
  parameter int NUM_DEV = 9,
  localparam int IDX_W  = $clog2(NUM_DEV),
  localparam int ONES_W = $clog2(NUM_DEV + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     fire,
  input  logic [NUM_DEV*SYM_W-1:0] calc_sums,
  input  logic [NUM_DEV*SYM_W-1:0] stored_sums,
  output logic                     done,
  output logic                     located,
  output logic [IDX_W-1:0]         dev_idx,
  output logic                     due
);
  logic [NUM_DEV-1:0] mism;
  logic [ONES_W-1:0]  n_mism;
  logic [IDX_W-1:0]   hit_idx;
  logic               single;

  // Both encodings of zero compare as equal.
  function automatic logic oc_equal(input logic [SYM_W-1:0] a, input logic [SYM_W-1:0] b);
    logic a_zero, b_zero;
    a_zero = (a == '0) || (a == '1);
    b_zero = (b == '0) || (b == '1);
    return (a == b) || (a_zero && b_zero);
  endfunction

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_lane
    assign mism[d] = !oc_equal(calc_sums[d*SYM_W +: SYM_W], stored_sums[d*SYM_W +: SYM_W]);
  end

  always_comb begin
    n_mism  = '0;
    hit_idx = '0;
    for (int i = 0; i < NUM_DEV; i++) begin
      if (mism[i]) begin
        n_mism  = n_mism + 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
    single = (n_mism == ONES_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      done    <= 1'b0;
      located <= 1'b0;
      due     <= 1'b0;
      dev_idx <= '0;
    end else if (fire) begin
      done    <= 1'b1;
      located <= single;
      due     <= !single;
      dev_idx <= single ? hit_idx : '0;
    end else begin
      done <= 1'b0;
    end
  end

  // R8: done lasts a single cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R6: a located device lies inside the rank
  p_idx_range_r6: assert property (@(posedge clk) disable iff (rst)
    located |-> (dev_idx < IDX_W'(NUM_DEV)));
  // R7: each verdict is either located or uncorrectable, never both
  p_one_verdict_r7: assert property (@(posedge clk) disable iff (rst) done |-> (located ^ due));
  // R7: no index is reported with an uncorrectable verdict
  p_due_idx_r7: assert property (@(posedge clk) disable iff (rst) due |-> (dev_idx == '0));
endmodule

// File: rtl/clg_localizer.sv
module clg_localizer #(
  parameter int SYM_W     = 16,
  parameter int NUM_DEV   = 9,
  parameter int GROUP_LEN = 256,
  localparam int IDX_W    = $clog2(NUM_DEV),
  localparam int WORD_W   = NUM_DEV * SYM_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              sym_valid,
  input  logic [WORD_W-1:0] sym_word,
  input  logic              stored_valid,
  input  logic [WORD_W-1:0] stored_sums,
  output logic              done,
  output logic              located,
  output logic [IDX_W-1:0]  dev_idx,
  output logic              due
);
  logic              acc_clr;
  logic              acc_en;
  logic              fire;
  logic [WORD_W-1:0] calc_sums;

  clg_ctrl #(.GROUP_LEN(GROUP_LEN)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .sym_valid    (sym_valid),
    .stored_valid (stored_valid),
    .acc_clr      (acc_clr),
    .acc_en       (acc_en),
    .fire         (fire)
  );

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    clg_ocsum_acc #(.SYM_W(SYM_W)) u_acc (
      .clk    (clk),
      .rst    (rst),
      .clr    (acc_clr),
      .add_en (acc_en),
      .sym    (sym_word[d*SYM_W +: SYM_W]),
      .acc    (calc_sums[d*SYM_W +: SYM_W])
    );
  end

  clg_verdict #(.SYM_W(SYM_W), .NUM_DEV(NUM_DEV)) u_verdict (
    .clk         (clk),
    .rst         (rst),
    .clr         (acc_clr),
    .fire        (fire),
    .calc_sums   (calc_sums),
    .stored_sums (stored_sums),
    .done        (done),
    .located     (located),
    .dev_idx     (dev_idx),
    .due         (due)
  );

  // R8: the verdict holds until a new start or a new accepted checksum set
  p_verdict_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!start && !fire) |=> ($stable(located) && $stable(due) && $stable(dev_idx)));
  // R2: start clears the verdict
  p_start_clears_r2: assert property (@(posedge clk) disable iff (rst)
    start |=> (!located && !due && !done));
endmodule

// File: tb/clg_localizer_tb.sv
module clg_localizer_tb;
  localparam int SW = 16;
  localparam int ND = 9;
  localparam int GL = 256;
  localparam int WW = SW * ND;

  typedef struct packed {
    logic [15:0] seed;
    logic [8:0]  flip;
    logic        exp_loc;
    logic [3:0]  exp_idx;
  } vec_t;

  localparam vec_t TBL [6] = '{
    '{seed: 16'd11,  flip: 9'h000, exp_loc: 1'b0, exp_idx: 4'd0},
    '{seed: 16'd23,  flip: 9'h001, exp_loc: 1'b1, exp_idx: 4'd0},
    '{seed: 16'd37,  flip: 9'h100, exp_loc: 1'b1, exp_idx: 4'd8},
    '{seed: 16'd41,  flip: 9'h010, exp_loc: 1'b1, exp_idx: 4'd4},
    '{seed: 16'd59,  flip: 9'h003, exp_loc: 1'b0, exp_idx: 4'd0},
    '{seed: 16'd67,  flip: 9'h1FF, exp_loc: 1'b0, exp_idx: 4'd0}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          sym_valid = 1'b0;
  logic [WW-1:0] sym_word = '0;
  logic          stored_valid = 1'b0;
  logic [WW-1:0] stored_sums = '0;
  logic          done, located, due;
  logic [3:0]    dev_idx;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [SW-1:0] exp_sum [ND];

  always #4 clk = ~clk;

  clg_localizer u_dut (
    .clk(clk), .rst(rst), .start(start), .sym_valid(sym_valid), .sym_word(sym_word),
    .stored_valid(stored_valid), .stored_sums(stored_sums),
    .done(done), .located(located), .dev_idx(dev_idx), .due(due)
  );

  function automatic logic [SW-1:0] oc_add(input logic [SW-1:0] a, input logic [SW-1:0] b);
    logic [SW:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[SW-1:0] + {{(SW-1){1'b0}}, s[SW]};
  endfunction

  // kind 0: hashed data, 1: all zero, 2: complement pair, 3: carry in lane 2
  function automatic logic [WW-1:0] make_word(input int kind, input int seed, input int c);
    logic [WW-1:0] w;
    w = '0;
    for (int d = 0; d < ND; d++) begin
      logic [31:0] h;
      h = 32'(seed) * 32'd40503 + 32'(c) * 32'd2654435761 + 32'(d) * 32'd7919 + 32'd12345;
      h = h ^ (h >> 13);
      h = h * 32'd1103515245;
      case (kind)
        0: w[d*SW +: SW] = h[31:16];
        2: w[d*SW +: SW] = (c == 0) ? 16'h1234 : ((c == 1) ? 16'hEDCB : 16'h0000);
        3: w[d*SW +: SW] = (d == 2 && c < 2) ? 16'h8000 : 16'h0000;
        default: w[d*SW +: SW] = 16'h0000;
      endcase
    end
    return w;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_group(input int kind, input int seed);
    for (int d = 0; d < ND; d++) exp_sum[d] = '0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int c = 0; c < GL; c++) begin
      logic [WW-1:0] w;
      w = make_word(kind, seed, c);
      for (int d = 0; d < ND; d++) exp_sum[d] = oc_add(exp_sum[d], w[d*SW +: SW]);
      sym_valid = 1'b1;
      sym_word  = w;
      @(negedge clk);
    end
    sym_valid = 1'b0;
    sym_word  = '0;
  endtask

  // presents checksums at a falling edge; returns at the next falling edge (verdict visible)
  task automatic give_stored(input logic [WW-1:0] st);
    stored_valid = 1'b1;
    stored_sums  = st;
    @(negedge clk);
    stored_valid = 1'b0;
    stored_sums  = '0;
  endtask

  function automatic logic [WW-1:0] true_sums(input logic [8:0] flip);
    logic [WW-1:0] st;
    for (int d = 0; d < ND; d++) st[d*SW +: SW] = exp_sum[d] ^ (flip[d] ? 16'h0001 : 16'h0000);
    return st;
  endfunction

  task automatic verdict(input string req, input logic el, input int ei);
    chk({req, " done"}, int'(done), 1);
    chk({req, " located"}, int'(located), int'(el));
    chk({req, " due"}, int'(due), int'(!el));
    chk({req, " dev_idx"}, int'(dev_idx), ei);
    @(negedge clk);
    chk("R8 done drops", int'(done), 0);
    chk("R8 located held", int'(located), int'(el));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [WW-1:0] st;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 done", int'(done), 0);
    chk("R1 located", int'(located), 0);
    chk("R1 due", int'(due), 0);
    chk("R1 dev_idx", int'(dev_idx), 0);

    // table walk: R3 sums, R6 single mismatch, R7 none or several, R2 clearing between groups
    for (int i = 0; i < 6; i++) begin
      run_group(0, int'(TBL[i].seed));
      give_stored(true_sums(TBL[i].flip));
      verdict(TBL[i].exp_loc ? "R6 table" : "R7 table", TBL[i].exp_loc, int'(TBL[i].exp_idx));
    end

    // R5: sums of 0x0000 against a stored 0xFFFF still match -> no mismatch -> due
    run_group(1, 0);
    st = '0;
    st[3*SW +: SW] = 16'hFFFF;
    give_stored(st);
    verdict("R5 zero vs FFFF", 1'b0, 0);

    // R5: sums of 0xFFFF against stored 0x0000 match; lane 5 differs -> located 5
    run_group(2, 0);
    st = '0;
    st[5*SW +: SW] = 16'h0001;
    give_stored(st);
    verdict("R5 FFFF vs zero", 1'b1, 5);

    // R3: 0x8000+0x8000 wraps to 0x0001 in lane 2; stored 0 mismatches there
    run_group(3, 0);
    st = '0;
    give_stored(st);
    verdict("R3 end-around carry mismatch", 1'b1, 2);
    run_group(3, 0);
    st = '0;
    st[2*SW +: SW] = 16'h0001;
    give_stored(st);
    verdict("R3 end-around carry match", 1'b0, 0);

    // R4: a beat after the group is full is ignored
    run_group(0, 77);
    sym_valid = 1'b1;
    sym_word  = {ND{16'h0101}};
    @(negedge clk);
    sym_valid = 1'b0;
    sym_word  = '0;
    give_stored(true_sums(9'h040));
    verdict("R4 extra beat ignored", 1'b1, 6);

    // R2: a partly streamed group is discarded by a new start
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int c = 0; c < 10; c++) begin
      sym_valid = 1'b1;
      sym_word  = {ND{16'h5555}};
      @(negedge clk);
    end
    sym_valid = 1'b0;
    run_group(0, 99);
    give_stored(true_sums(9'h002));
    verdict("R2 restart discards", 1'b1, 1);

    // R9: checksums outside the compare phase have no effect
    give_stored({ND{16'h0F0F}});
    chk("R9 idle stored no done", int'(done), 0);
    chk("R9 idle stored located", int'(located), 1);
    chk("R9 idle stored dev_idx", int'(dev_idx), 1);
    repeat (3) @(negedge clk);
    chk("R8 verdict held", int'(located), 1);

    // R2: start clears the verdict
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R2 start clears located", int'(located), 0);
    chk("R2 start clears due", int'(due), 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule